// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is one storage cell used by several hardware threads to pass 64-bit words to each other. Its heart is an eight-entry circular buffer. A tag word sits beside the buffer and holds an empty flag (E), a full flag (F), a trap flag (T), a FIFO-kind flag, the occupancy count and a depth code. Each request carries a two-bit view code that chooses how the access behaves. The bypass view (0) peeks at the head entry or patches the newest entry. The control view (1) reads the packed tag word or writes the flags. The blocking view (2) and the non-blocking view (3) push on a write and pop on a read.

When a blocking access cannot proceed, the cell answers with a stall code. It also records the requester's ID in a 64-bit waiter mask, so the thread scheduler can retry that requester later. A non-blocking access that cannot proceed is refused and nothing is recorded. Every successful push or pop sends one wake pulse that carries the whole waiter mask, and then clears the mask.

Requests are handled one at a time by a three-state sequencer:
- ST_IDLE is the only state that accepts a request. It moves to ST_EXEC when `req_valid` is high.
- In ST_EXEC the cell applies the access to the buffer, the flags and the waiter mask, then moves to ST_RESP.
- ST_RESP presents the response for one cycle and returns to ST_IDLE.

Top module: `tfc_cell`

## Requirements
- R1: After reset, the control view reads 0x0000_0000_3002_0001. This is depth code 3 in bits [31:28], FIFO flag set in bit 17, and E=1 in bit 0. The count is zero, both pointers are zero and all data entries are zero.
- R2: A control-view read returns the tag word with these fields: depth code in [31:28], occupancy count in [21:18], FIFO flag in bit 17, T in bit 16, F in bit 1, E in bit 0. All other bits are zero.
- R3: A control-view write loads T from bit 16, E from bit 0 and F from bit 1 of the write data. If the written E is 1, the count and the read pointer are also cleared. After such a write, the flags, not the count, decide whether a push or a pop may proceed.
- R4: A pop (view 2 or 3, read) with E=0 returns the head entry and advances the read pointer modulo 8. It decrements the count and clears F. It sets E when the count reaches zero. Entries leave in the order they were pushed.
- R5: A push (view 2 or 3, write) with F=0 stores its data at (read pointer + count) modulo 8, increments the count and clears E. It sets F when the count reaches 8.
- R6: A blocking push while F=1, or a blocking pop while E=1, responds with code 1 (stall). It sets the requester's bit in the waiter mask and changes neither the data, the count nor the flags.
- R7: A non-blocking push while F=1, or a non-blocking pop while E=1, responds with code 2 (refused) and read data zero. It changes nothing and records no waiter.
- R8: Each successful push or pop sets `wake_valid` in its response cycle, with `wake_mask` equal to the waiter mask held before the operation. It then clears the waiter mask. When no waiter is recorded, `wake_valid` stays low.
- R9: A bypass-view read returns the head entry and changes neither the pointers, the count nor the flags.
- R10: A bypass-view write overwrites the most recently pushed entry at (read pointer + count − 1) modulo 8 when the count is nonzero. When the count is zero it is ignored.
- R11: `req_ready` is high only in ST_IDLE. A request accepted at a rising edge gets `resp_valid` high for exactly one cycle, starting two rising edges later. Code 0 means done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cell can accept a request (ST_IDLE) |
| req_view | input | 2 | View code: 0 bypass, 1 control, 2 blocking, 3 non-blocking |
| req_write | input | 1 | 1 for write/push, 0 for read/pop |
| req_id | input | 6 | Requester ID, used as the waiter mask index |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response present for one cycle |
| resp_code | output | 2 | 0 done, 1 stall, 2 refused |
| resp_rdata | output | 64 | Read data, zero for writes |
| wake_valid | output | 1 | Wake pulse for recorded waiters |
| wake_mask | output | 64 | Requesters being woken |

## Verification
The assertions assume that `rst` is held for at least one clock. They also assume that the request fields are stable while `req_valid` is high in ST_IDLE. The stall and refusal checks assume that requests are issued only through that handshake, never overlapping an access already in flight.

The bench drives every request at a falling edge, only after it has seen `req_ready` high. It drops `req_valid` one cycle later and waits for `resp_valid` before it issues the next request. All requester IDs it uses lie within the 64-entry mask.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [1:0] {
        VW_BYPASS = 2'd0,
        VW_CTRL   = 2'd1,
        VW_SYNC   = 2'd2,
        VW_TRY    = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        RC_DONE    = 2'd0,
        RC_STALL   = 2'd1,
        RC_REFUSED = 2'd2
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    // Tag word bit positions (software decodes these)
    localparam int TAG_DEPTH_LSB = 28;
    localparam int TAG_CNT_LSB   = 18;
    localparam int TAG_KIND_BIT  = 17;
    localparam int TAG_T_BIT     = 16;
    localparam int TAG_F_BIT     = 1;
    localparam int TAG_E_BIT     = 0;

endpackage

// File: rtl/tfc_store.sv
module tfc_store #(
    parameter int DATA_W     = 64,
    parameter int DEPTH_LOG2 = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DEPTH_LOG2-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && wr_addr == DEPTH_LOG2'(i)) begin
                mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tfc_waiters.sv
module tfc_waiters #(
    parameter int RID_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rec_en,
    input  logic [RID_W-1:0]        rec_id,
    input  logic                    wake_en,
    output logic [(1<<RID_W)-1:0]   mask_o,
    output logic                    wake_valid,
    output logic [(1<<RID_W)-1:0]   wake_mask
);
    localparam int NREQ = 1 << RID_W;

    logic [NREQ-1:0] slot;

    for (genvar i = 0; i < NREQ; i++) begin : g_slot
        logic held_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q <= 1'b0;
            end else if (wake_en) begin
                held_q <= 1'b0;
            end else if (rec_en && rec_id == RID_W'(i)) begin
                held_q <= 1'b1;
            end
        end
        assign slot[i] = held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else begin
            wake_valid <= wake_en && (|slot);
            wake_mask  <= wake_en ? slot : '0;
        end
    end

    assign mask_o = slot;

endmodule

// File: rtl/tfc_ctrl.sv
module tfc_ctrl
    import tfc_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int DEPTH_LOG2 = 3,
    parameter int RID_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_view,
    input  logic                  req_write,
    input  logic [RID_W-1:0]      req_id,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  resp_valid,
    output logic [1:0]            resp_code,
    output logic [DATA_W-1:0]     resp_rdata,
    output logic                  st_wr_en,
    output logic [DEPTH_LOG2-1:0] st_wr_addr,
    output logic [DATA_W-1:0]     st_wr_data,
    output logic [DEPTH_LOG2-1:0] st_rd_addr,
    input  logic [DATA_W-1:0]     st_rd_data,
    output logic                  wt_rec_en,
    output logic [RID_W-1:0]      wt_rec_id,
    output logic                  wt_wake_en,
    output logic [DEPTH_LOG2:0]   occ_o,
    output logic                  empty_o,
    output logic                  full_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int CNT_W = DEPTH_LOG2 + 1;
    localparam int PTR_W = DEPTH_LOG2;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    // Sequencer
    state_e state_q, state_d;

    // Latched request
    view_e             view_q;
    logic              wr_q;
    logic [RID_W-1:0]  id_q;
    logic [DATA_W-1:0] wdata_q;

    // Cell state
    logic [PTR_W-1:0] rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             e_q, f_q, t_q;

    // Response registers
    resp_e             code_q;
    logic [DATA_W-1:0] rdata_q;

    // Decode
    logic exec, is_ef, pop_req, push_req, pop_go, push_go;
    logic hold, stall, refuse, has_room, nonzero, byp_wr, ctl_wr;
    logic [PTR_W-1:0]  tail_ptr, last_ptr;
    logic [DATA_W-1:0] tag_word, rsel;
    resp_e             code_d;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs of the sequencer ----------------
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_EXEC: ;
            ST_RESP: resp_valid = 1'b1;
            default: ;
        endcase
        resp_code  = code_q;
        resp_rdata = rdata_q;
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            view_q  <= VW_BYPASS;
            wr_q    <= 1'b0;
            id_q    <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            view_q  <= view_e'(req_view);
            wr_q    <= req_write;
            id_q    <= req_id;
            wdata_q <= req_wdata;
        end
    end

    // ---------------- operation decode ----------------
    always_comb begin
        exec     = (state_q == ST_EXEC);
        is_ef    = (view_q == VW_SYNC) || (view_q == VW_TRY);
        pop_req  = exec && is_ef && !wr_q;
        push_req = exec && is_ef && wr_q;
        pop_go   = pop_req && !e_q;
        push_go  = push_req && !f_q;
        hold     = (pop_req && e_q) || (push_req && f_q);
        stall    = hold && (view_q == VW_SYNC);
        refuse   = hold && (view_q == VW_TRY);
        has_room = (cnt_q < CNT_MAX);
        nonzero  = (cnt_q != '0);
        tail_ptr = rptr_q + cnt_q[PTR_W-1:0];
        last_ptr = tail_ptr - PTR_W'(1);
        byp_wr   = exec && (view_q == VW_BYPASS) && wr_q && nonzero;
        ctl_wr   = exec && (view_q == VW_CTRL) && wr_q;
    end

    assign st_wr_en   = (push_go && has_room) || byp_wr;
    assign st_wr_addr = push_go ? tail_ptr : last_ptr;
    assign st_wr_data = wdata_q;
    assign st_rd_addr = rptr_q;

    assign wt_rec_en  = stall;
    assign wt_rec_id  = id_q;
    assign wt_wake_en = pop_go || push_go;

    // ---------------- tag word ----------------
    always_comb begin
        tag_word = '0;
        tag_word[TAG_DEPTH_LSB +: 4]   = 4'(DEPTH_LOG2);
        tag_word[TAG_CNT_LSB +: CNT_W] = cnt_q;
        tag_word[TAG_KIND_BIT]         = 1'b1;
        tag_word[TAG_T_BIT]            = t_q;
        tag_word[TAG_F_BIT]            = f_q;
        tag_word[TAG_E_BIT]            = e_q;
    end

    // ---------------- pointers and flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
            cnt_q  <= '0;
            e_q    <= 1'b1;
            f_q    <= 1'b0;
            t_q    <= 1'b0;
        end else if (pop_go) begin
            f_q <= 1'b0;
            if (nonzero) begin
                rptr_q <= rptr_q + PTR_W'(1);
                cnt_q  <= cnt_q - CNT_W'(1);
                e_q    <= (cnt_q == CNT_W'(1));
            end else begin
                e_q <= 1'b1;
            end
        end else if (push_go) begin
            e_q <= 1'b0;
            if (has_room) begin
                cnt_q <= cnt_q + CNT_W'(1);
                f_q   <= (cnt_q == CNT_MAX - CNT_W'(1));
            end else begin
                f_q <= 1'b1;
            end
        end else if (ctl_wr) begin
            t_q <= wdata_q[TAG_T_BIT];
            e_q <= wdata_q[TAG_E_BIT];
            f_q <= wdata_q[TAG_F_BIT];
            if (wdata_q[TAG_E_BIT]) begin
                cnt_q  <= '0;
                rptr_q <= '0;
            end
        end
    end

    // ---------------- response selection ----------------
    always_comb begin
        unique case (view_q)
            VW_BYPASS: rsel = wr_q ? '0 : st_rd_data;
            VW_CTRL:   rsel = wr_q ? '0 : tag_word;
            VW_SYNC,
            VW_TRY:    rsel = (pop_go && nonzero) ? st_rd_data : '0;
            default:   rsel = '0;
        endcase
        if (stall) begin
            code_d = RC_STALL;
        end else if (refuse) begin
            code_d = RC_REFUSED;
        end else begin
            code_d = RC_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= RC_DONE;
            rdata_q <= '0;
        end else if (exec) begin
            code_q  <= code_d;
            rdata_q <= rsel;
        end
    end

    assign occ_o   = cnt_q;
    assign empty_o = e_q;
    assign full_o  = f_q;

endmodule

// File: rtl/tfc_cell.sv
module tfc_cell #(
    parameter int DATA_W     = 64,
    parameter int DEPTH_LOG2 = 3,
    parameter int RID_W      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_view,
    input  logic                   req_write,
    input  logic [RID_W-1:0]       req_id,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   resp_valid,
    output logic [1:0]             resp_code,
    output logic [DATA_W-1:0]      resp_rdata,
    output logic                   wake_valid,
    output logic [(1<<RID_W)-1:0]  wake_mask
);
    localparam int NREQ = 1 << RID_W;

    logic                  st_wr_en;
    logic [DEPTH_LOG2-1:0] st_wr_addr, st_rd_addr;
    logic [DATA_W-1:0]     st_wr_data, st_rd_data;
    logic                  wt_rec_en, wt_wake_en;
    logic [RID_W-1:0]      wt_rec_id;
    logic [NREQ-1:0]       wait_mask;
    logic [DEPTH_LOG2:0]   occ;
    logic                  empty_flag, full_flag;

    tfc_ctrl #(
        .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2), .RID_W(RID_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_view(req_view), .req_write(req_write),
        .req_id(req_id), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata),
        .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
        .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data),
        .wt_rec_en(wt_rec_en), .wt_rec_id(wt_rec_id), .wt_wake_en(wt_wake_en),
        .occ_o(occ), .empty_o(empty_flag), .full_o(full_flag)
    );

    tfc_store #(
        .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(st_wr_en), .wr_addr(st_wr_addr), .wr_data(st_wr_data),
        .rd_addr(st_rd_addr), .rd_data(st_rd_data)
    );

    tfc_waiters #(
        .RID_W(RID_W)
    ) u_waiters (
        .clk(clk), .rst(rst),
        .rec_en(wt_rec_en), .rec_id(wt_rec_id), .wake_en(wt_wake_en),
        .mask_o(wait_mask), .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

endmodule

// File: rtl/tfc_cell_chk.sv
module tfc_cell_chk #(
    parameter int DEPTH_LOG2 = 3,
    parameter int RID_W      = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   resp_valid,
    input logic [1:0]             resp_code,
    input logic                   wake_valid,
    input logic [DEPTH_LOG2:0]    occ,
    input logic                   empty_flag,
    input logic                   full_flag,
    input logic [(1<<RID_W)-1:0]  wait_mask,
    input logic [RID_W-1:0]       rec_id
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (rst)
        occ <= (DEPTH_LOG2+1)'(DEPTH));

    p_full_on_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (occ == (DEPTH_LOG2+1)'(DEPTH) && $past(occ) != (DEPTH_LOG2+1)'(DEPTH)) |-> full_flag);

    p_empty_on_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && $past(occ) != '0) |-> empty_flag);

    p_stall_keeps_count_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'd1) |-> occ == $past(occ));

    p_stall_records_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'd1) |-> wait_mask[rec_id]);

    p_refuse_no_record_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_code == 2'd2) |-> wait_mask == $past(wait_mask));

    p_wake_clears_r8: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> wait_mask == '0);

endmodule

bind tfc_cell tfc_cell_chk #(.DEPTH_LOG2(DEPTH_LOG2), .RID_W(RID_W)) u_chk (
    .clk(clk), .rst(rst),
    .resp_valid(resp_valid), .resp_code(resp_code), .wake_valid(wake_valid),
    .occ(occ), .empty_flag(empty_flag), .full_flag(full_flag),
    .wait_mask(wait_mask), .rec_id(wt_rec_id)
);

// File: tb/tb_tfc_cell.sv
`timescale 1ns/1ps
module tb_tfc_cell;

    localparam logic [1:0] V_BYP  = 2'd0;
    localparam logic [1:0] V_CTL  = 2'd1;
    localparam logic [1:0] V_SYNC = 2'd2;
    localparam logic [1:0] V_TRY  = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_view = 2'd0;
    logic        req_write = 1'b0;
    logic [5:0]  req_id = 6'd0;
    logic [63:0] req_wdata = 64'd0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [63:0] resp_rdata;
    logic        wake_valid;
    logic [63:0] wake_mask;

    always #2.5 clk = ~clk;

    tfc_cell dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_view(req_view), .req_write(req_write),
        .req_id(req_id), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_rdata(resp_rdata),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // response capture
    logic [1:0]  r_code;
    logic [63:0] r_data;
    logic        r_wv;
    logic [63:0] r_wm;
    int          r_lat;

    // requirement-level model
    logic [63:0] m_data [8];
    int          m_rp, m_cnt;
    logic        m_e, m_f, m_t;

    function automatic logic [63:0] tag_exp();
        logic [63:0] v;
        v = 64'h3000_0000;
        v[21:18] = 4'(m_cnt);
        v[17] = 1'b1;
        v[16] = m_t;
        v[1]  = m_f;
        v[0]  = m_e;
        return v;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] v, input logic w,
                         input logic [5:0] id, input logic [63:0] d);
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_view = v; req_write = w; req_id = id; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        r_code = resp_code; r_data = resp_rdata;
        r_wv = wake_valid; r_wm = wake_mask; r_lat = lat;
    endtask

    task automatic ctrl_read(input string rq);
        do_op(V_CTL, 1'b0, 6'd0, 64'd0);
        check(rq, "tag word", r_data, tag_exp());
    endtask

    task automatic ctrl_write(input logic [63:0] d);
        do_op(V_CTL, 1'b1, 6'd0, d);
        m_t = d[16]; m_e = d[0]; m_f = d[1];
        if (d[0]) begin m_cnt = 0; m_rp = 0; end
    endtask

    task automatic push_ok(input logic [1:0] v, input logic [63:0] val, input string rq);
        do_op(v, 1'b1, 6'd1, val);
        check(rq, "push code", 64'(r_code), 64'd0);
        m_data[(m_rp + m_cnt) % 8] = val;
        m_cnt++; m_e = 1'b0;
        if (m_cnt == 8) m_f = 1'b1;
    endtask

    task automatic pop_ok(input logic [1:0] v, input string rq);
        do_op(v, 1'b0, 6'd2, 64'd0);
        check(rq, "pop code", 64'(r_code), 64'd0);
        check(rq, "pop data", r_data, m_data[m_rp]);
        m_rp = (m_rp + 1) % 8; m_cnt--; m_f = 1'b0;
        if (m_cnt == 0) m_e = 1'b1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R11", "ready after reset", 64'(req_ready), 64'd1);
        check("R11", "no response after reset", 64'(resp_valid), 64'd0);
        check("R1", "no wake after reset", 64'(wake_valid), 64'd0);
        do_op(V_CTL, 1'b0, 6'd0, 64'd0);
        check("R1", "reset tag word", r_data, 64'h0000_0000_3002_0001);
        check("R11", "response latency", 64'(r_lat), 64'd2);
        @(negedge clk);
        check("R11", "response lasts one cycle", 64'(resp_valid), 64'd0);
        do_op(V_BYP, 1'b0, 6'd0, 64'd0);
        check("R1", "reset data zero", r_data, 64'd0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 8; i++) push_ok(V_TRY, {32'hC0DE_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)}, "R5");
        ctrl_read("R5");
        check("R2", "count field", 64'(r_data[21:18]), 64'd8);
        check("R2", "F bit 1", 64'(r_data[1]), 64'd1);
        do_op(V_TRY, 1'b1, 6'd7, 64'hDEAD);
        check("R7", "try push full code", 64'(r_code), 64'd2);
        check("R7", "try push no wake", 64'(r_wv), 64'd0);
        ctrl_read("R7");
    endtask

    task automatic t_block();
        do_op(V_SYNC, 1'b1, 6'd5, 64'hBEEF);
        check("R6", "blocking push full code", 64'(r_code), 64'd1);
        ctrl_read("R6");
        pop_ok(V_SYNC, "R4");
        check("R8", "wake on pop", 64'(r_wv), 64'd1);
        check("R8", "wake mask", r_wm, 64'd1 << 5);
        push_ok(V_SYNC, 64'h1111_2222_3333_4444, "R5");
        check("R8", "mask cleared, no wake", 64'(r_wv), 64'd0);
    endtask

    task automatic t_bypass();
        do_op(V_BYP, 1'b0, 6'd0, 64'd0);
        check("R9", "bypass read head", r_data, m_data[m_rp]);
        do_op(V_BYP, 1'b0, 6'd0, 64'd0);
        check("R9", "bypass read repeat", r_data, m_data[m_rp]);
        ctrl_read("R9");
        do_op(V_BYP, 1'b1, 6'd0, 64'hFACE_FACE_FACE_FACE);
        check("R10", "bypass write code", 64'(r_code), 64'd0);
        m_data[(m_rp + m_cnt - 1) % 8] = 64'hFACE_FACE_FACE_FACE;
        for (int i = 0; i < 8; i++) pop_ok(V_TRY, "R4");
        ctrl_read("R4");
    endtask

    task automatic t_empty();
        do_op(V_BYP, 1'b1, 6'd0, 64'h0BAD_0BAD_0BAD_0BAD);
        ctrl_read("R10");
        ctrl_write(64'h1);
        do_op(V_BYP, 1'b0, 6'd0, 64'd0);
        check("R10", "ignored bypass write slot", r_data, m_data[0]);
        do_op(V_TRY, 1'b0, 6'd4, 64'd0);
        check("R7", "try pop empty code", 64'(r_code), 64'd2);
        check("R7", "try pop empty data", r_data, 64'd0);
        do_op(V_SYNC, 1'b0, 6'd3, 64'd0);
        check("R6", "blocking pop empty code", 64'(r_code), 64'd1);
        push_ok(V_TRY, 64'h7777_8888_9999_AAAA, "R5");
        check("R8", "wake on push", 64'(r_wv), 64'd1);
        check("R8", "wake mask id 3", r_wm, 64'd1 << 3);
        pop_ok(V_TRY, "R4");
    endtask

    task automatic t_ctrl();
        push_ok(V_SYNC, 64'hA1, "R5");
        push_ok(V_SYNC, 64'hB2, "R5");
        ctrl_write(64'h0001_0000);
        ctrl_read("R3");
        ctrl_write(64'h2);
        ctrl_read("R3");
        do_op(V_TRY, 1'b1, 6'd1, 64'hC3);
        check("R3", "F flag governs push", 64'(r_code), 64'd2);
        ctrl_write(64'h1);
        ctrl_read("R3");
        push_ok(V_SYNC, 64'hC3, "R3");
        do_op(V_BYP, 1'b0, 6'd0, 64'd0);
        check("R3", "head at slot 0 after clear", r_data, 64'hC3);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_data[i] = 64'd0;
        m_rp = 0; m_cnt = 0; m_e = 1'b1; m_f = 1'b0; m_t = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_block();
        t_bypass();
        t_empty();
        t_ctrl();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule